// File: doc/BRIEF.md
# Converter Conversion Request Sequencer

This block drives a single software-style conversion on an attached converter register file. It acts as a master on a simple request/acknowledge register bus. A client presents a channel number with a one-cycle request. The block then works through a fixed list of register accesses and returns a 16-bit raw result together with an error flag.

For each request the block polls the converter's status register until its busy flag clears, giving up after a bounded number of reads. It sets the enable bit in control register 1 with a read-modify-write, then writes the channel and a 16-sample averaging code into control register 2. It sets the buffer bit in control register 1 the same way, and sets the start bit last. For one configurable temperature channel, the buffer update also sets a pull-up bit, and the block waits a settling time before it starts the conversion. After the start it waits for a conversion-end interrupt, bounded by a timeout. It reads the result's low byte and then its high byte. Every exit path ends with a write of zero to control register 1, whether the request succeeded, the poll ran out, the interrupt timed out or the bus returned an error.

The states are IDLE, POLL, EN_RD, EN_WR, CFG_WR, BUF_RD, BUF_WR, SETTLE, GO_RD, GO_WR, WAIT, LO_RD, HI_RD and OFF_WR.

The transitions are:
- IDLE→POLL on an accepted request.
- POLL→EN_RD when the busy flag reads clear. POLL→POLL when it reads set with polls left. POLL→OFF_WR when it reads set on the last poll.
- EN_RD→EN_WR→CFG_WR→BUF_RD on each acknowledge.
- BUF_WR→SETTLE for the pull-up channel, and BUF_WR→GO_RD otherwise.
- SETTLE→GO_RD when the timer expires.
- GO_RD→GO_WR→WAIT on each acknowledge.
- WAIT→LO_RD on the interrupt, and WAIT→OFF_WR on timeout.
- LO_RD→HI_RD→OFF_WR on each acknowledge.
- Any bus access state→OFF_WR on a bus error.
- OFF_WR→IDLE on acknowledge or error.

Top module: `cnv_seq_top`

## Requirements
- R1: After reset, busy, done, err, bus_req and result are all 0.
- R2: A request is accepted only in IDLE, and busy is 1 on the cycle after acceptance. A request presented while busy is ignored: the channel written is the accepted one, and no second conversion follows.
- R3: The status register (address 0x04, busy flag at bit 0) is read until bit 0 reads 0, at most POLL_LIMIT times. If all POLL_LIMIT reads show busy, the request fails and control register 2 is never written.
- R4: Control register 1 (address 0x00) is updated by read-modify-write in this order: OR 0x01 (enable), then OR 0x20 (buffer), then OR 0x04 (start). Bits already present are preserved. Between the first two updates, control register 2 (address 0x01) is written once with the channel ORed with 0x60.
- R5: When PULL_EN is set and the channel equals TEMP_CHAN, the buffer update also ORs 0x08. The read that precedes the start write then comes SETTLE_CYC+3+L cycles after the buffer write, where L is the bus wait count. For other channels this gap is 2+L.
- R6: After the start write the block waits for conv_irq. If the interrupt does not arrive, the request fails, and the disable write comes TIMEOUT_CYC+3+L cycles after the start write.
- R7: The low byte (0x05) is read immediately before the high byte (0x06), and on success result = {high, low}.
- R8: The last access of every request is a write of 0x00 to address 0x00, whatever the outcome. done is a one-cycle pulse on the cycle after that write is answered, with busy already 0.
- R9: A bus error on any access sends the block straight to the disable write with no other access in between, and ends with err = 1.
- R10: Whenever err is 1 at done, result is 0.
- R11: While bus_req is high and not yet answered, bus_addr, bus_we and bus_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request, sampled in IDLE |
| req_chan | input | CHAN_W | Channel to convert |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag of the last request, held until the next request |
| result | output | 16 | Raw result {high, low}; zero on failure |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completed; read data valid |
| bus_rdata | input | 8 | Read data |
| bus_err | input | 1 | Access failed |
| conv_irq | input | 1 | Conversion-end interrupt |

## Verification
Every access finishes on the edge where the bus answers, and the next access starts on the following cycle. done and err arrive one cycle after the disable write is answered, so the bench polls done on falling edges and samples result and err in that same half-cycle. The settling and timeout windows are checked as exact cycle gaps between logged bus transactions (N+3+L). This pins down the timer load and expiry edges without looking inside the design. A bus model records each access with its cycle number, and the order, values and counts of the accesses are compared with lists computed from the requirements.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

    localparam int ADDR_W = 8;
    localparam int REG_W  = 8;
    localparam int RES_W  = 2 * REG_W;

    // register addresses (decoded by the attached register file)
    localparam logic [ADDR_W-1:0] A_CTRL1  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTRL2  = 8'h01;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] A_RES_LO = 8'h05;
    localparam logic [ADDR_W-1:0] A_RES_HI = 8'h06;

    // control / status field values
    localparam logic [REG_W-1:0] M_ENABLE = 8'h01;
    localparam logic [REG_W-1:0] M_START  = 8'h04;
    localparam logic [REG_W-1:0] M_PULLUP = 8'h08;
    localparam logic [REG_W-1:0] M_BUFFER = 8'h20;
    localparam logic [REG_W-1:0] V_AVG16  = 8'h60;
    localparam logic [REG_W-1:0] V_OFF    = 8'h00;
    localparam int               BUSY_BIT = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL,
        S_EN_RD,
        S_EN_WR,
        S_CFG_WR,
        S_BUF_RD,
        S_BUF_WR,
        S_SETTLE,
        S_GO_RD,
        S_GO_WR,
        S_WAIT,
        S_LO_RD,
        S_HI_RD,
        S_OFF_WR
    } seq_state_t;

    // true for states that own a bus access
    function automatic logic is_access(input seq_state_t s);
        return !(s == S_IDLE || s == S_SETTLE || s == S_WAIT);
    endfunction

endpackage

// File: rtl/cnv_cycle_timer.sv
module cnv_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cnv_poll_counter.sv
module cnv_poll_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int PC_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [PC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the read now in flight is the final permitted one
    assign last = (cnt_q == PC_W'(LIMIT - 1));

endmodule

// File: rtl/cnv_access_decode.sv
module cnv_access_decode
    import cnv_seq_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  seq_state_t        state,
    input  logic [CHAN_W-1:0] chan,
    input  logic [REG_W-1:0]  hold,
    input  logic              pull,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_wdata
);

    localparam int PAD_W = REG_W - CHAN_W;

    logic [REG_W-1:0] chan_ext;
    logic [REG_W-1:0] buf_bits;

    assign chan_ext = {{PAD_W{1'b0}}, chan};
    assign buf_bits = pull ? (M_BUFFER | M_PULLUP) : M_BUFFER;

    always_comb begin
        bus_req   = is_access(state);
        bus_we    = 1'b0;
        bus_addr  = A_CTRL1;
        bus_wdata = V_OFF;
        unique case (state)
            S_POLL:   bus_addr = A_STATUS;
            S_EN_RD:  bus_addr = A_CTRL1;
            S_EN_WR: begin
                bus_we    = 1'b1;
                bus_wdata = hold | M_ENABLE;
            end
            S_CFG_WR: begin
                bus_we    = 1'b1;
                bus_addr  = A_CTRL2;
                bus_wdata = chan_ext | V_AVG16;
            end
            S_BUF_RD: bus_addr = A_CTRL1;
            S_BUF_WR: begin
                bus_we    = 1'b1;
                bus_wdata = hold | buf_bits;
            end
            S_GO_RD:  bus_addr = A_CTRL1;
            S_GO_WR: begin
                bus_we    = 1'b1;
                bus_wdata = hold | M_START;
            end
            S_LO_RD:  bus_addr = A_RES_LO;
            S_HI_RD:  bus_addr = A_RES_HI;
            S_OFF_WR: begin
                bus_we    = 1'b1;
                bus_wdata = V_OFF;
            end
            default: begin
                bus_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cnv_seq_fsm.sv
module cnv_seq_fsm
    import cnv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ack,
    input  logic       bus_err,
    input  logic       stat_busy,
    input  logic       poll_last,
    input  logic       use_pull,
    input  logic       tmr_expired,
    input  logic       conv_irq,
    output seq_state_t state,
    output logic       accept,
    output logic       poll_step,
    output logic       load_settle,
    output logic       load_timeout,
    output logic       cap_hold,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       set_fail,
    output logic       finish
);

    seq_state_t state_q;
    seq_state_t nxt;
    logic       ok;

    assign state = state_q;
    assign ok    = bus_ack && !bus_err;

    function automatic seq_state_t adv(input seq_state_t cur, input seq_state_t to,
                                       input logic ack, input logic er);
        if (er)       return S_OFF_WR;
        else if (ack) return to;
        else          return cur;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // next state
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) nxt = S_POLL;
            S_POLL: begin
                if (bus_err)                   nxt = S_OFF_WR;
                else if (bus_ack && !stat_busy) nxt = S_EN_RD;
                else if (bus_ack && poll_last)  nxt = S_OFF_WR;
            end
            S_EN_RD:  nxt = adv(state_q, S_EN_WR, bus_ack, bus_err);
            S_EN_WR:  nxt = adv(state_q, S_CFG_WR, bus_ack, bus_err);
            S_CFG_WR: nxt = adv(state_q, S_BUF_RD, bus_ack, bus_err);
            S_BUF_RD: nxt = adv(state_q, S_BUF_WR, bus_ack, bus_err);
            S_BUF_WR: nxt = adv(state_q, use_pull ? S_SETTLE : S_GO_RD, bus_ack, bus_err);
            S_SETTLE: if (tmr_expired) nxt = S_GO_RD;
            S_GO_RD:  nxt = adv(state_q, S_GO_WR, bus_ack, bus_err);
            S_GO_WR:  nxt = adv(state_q, S_WAIT, bus_ack, bus_err);
            S_WAIT: begin
                if (conv_irq)         nxt = S_LO_RD;
                else if (tmr_expired) nxt = S_OFF_WR;
            end
            S_LO_RD:  nxt = adv(state_q, S_HI_RD, bus_ack, bus_err);
            S_HI_RD:  nxt = adv(state_q, S_OFF_WR, bus_ack, bus_err);
            S_OFF_WR: if (bus_ack || bus_err) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        accept       = 1'b0;
        poll_step    = 1'b0;
        load_settle  = 1'b0;
        load_timeout = 1'b0;
        cap_hold     = 1'b0;
        cap_lo       = 1'b0;
        cap_hi       = 1'b0;
        set_fail     = 1'b0;
        finish       = 1'b0;
        unique case (state_q)
            S_IDLE:   accept = req_valid;
            S_POLL: begin
                poll_step = ok && stat_busy;
                set_fail  = bus_err || (ok && stat_busy && poll_last);
            end
            S_EN_RD, S_BUF_RD, S_GO_RD: begin
                cap_hold = ok;
                set_fail = bus_err;
            end
            S_BUF_WR: begin
                load_settle = ok && use_pull;
                set_fail    = bus_err;
            end
            S_GO_WR: begin
                load_timeout = ok;
                set_fail     = bus_err;
            end
            S_WAIT:   set_fail = !conv_irq && tmr_expired;
            S_LO_RD: begin
                cap_lo   = ok;
                set_fail = bus_err;
            end
            S_HI_RD: begin
                cap_hi   = ok;
                set_fail = bus_err;
            end
            S_OFF_WR: finish = bus_ack || bus_err;
            default:  set_fail = bus_err;
        endcase
    end

endmodule

// File: rtl/cnv_seq_top.sv
module cnv_seq_top
    import cnv_seq_pkg::*;
#(
    parameter int CHAN_W     = 5,
    parameter int TEMP_CHAN  = 6,
    parameter bit PULL_EN    = 1'b1,
    parameter int POLL_LIMIT = 10,
    parameter int CLK_KHZ    = 250000,
    parameter int SETTLE_US  = 1000,
    parameter int TIMEOUT_MS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RES_W-1:0]  result,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [REG_W-1:0]  bus_rdata,
    input  logic              bus_err,
    input  logic              conv_irq
);

    localparam int SETTLE_CYC  = (CLK_KHZ * SETTLE_US) / 1000;
    localparam int TIMEOUT_CYC = CLK_KHZ * TIMEOUT_MS;
    localparam int TMR_MAX     = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);

    seq_state_t        state;
    logic              accept, poll_step, load_settle, load_timeout;
    logic              cap_hold, cap_lo, cap_hi, set_fail, finish;
    logic              poll_last, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic [CHAN_W-1:0] chan_q;
    logic              pull_q, fail_q;
    logic [REG_W-1:0]  hold_q, lo_q;
    logic              done_q, err_q;
    logic [RES_W-1:0]  result_q;

    cnv_seq_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .bus_ack      (bus_ack),
        .bus_err      (bus_err),
        .stat_busy    (bus_rdata[BUSY_BIT]),
        .poll_last    (poll_last),
        .use_pull     (pull_q),
        .tmr_expired  (tmr_expired),
        .conv_irq     (conv_irq),
        .state        (state),
        .accept       (accept),
        .poll_step    (poll_step),
        .load_settle  (load_settle),
        .load_timeout (load_timeout),
        .cap_hold     (cap_hold),
        .cap_lo       (cap_lo),
        .cap_hi       (cap_hi),
        .set_fail     (set_fail),
        .finish       (finish)
    );

    cnv_poll_counter #(.LIMIT(POLL_LIMIT)) poll_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (poll_step),
        .last  (poll_last)
    );

    assign tmr_val = load_settle ? TMR_W'(SETTLE_CYC) : TMR_W'(TIMEOUT_CYC);

    cnv_cycle_timer #(.CNT_W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_settle | load_timeout),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cnv_access_decode #(.CHAN_W(CHAN_W)) dec_i (
        .state     (state),
        .chan      (chan_q),
        .hold      (hold_q),
        .pull      (pull_q),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '0;
            pull_q   <= 1'b0;
            fail_q   <= 1'b0;
            hold_q   <= '0;
            lo_q     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= finish;
            if (accept) begin
                chan_q   <= req_chan;
                pull_q   <= PULL_EN && (req_chan == CHAN_W'(TEMP_CHAN));
                fail_q   <= 1'b0;
                err_q    <= 1'b0;
                result_q <= '0;
            end
            if (set_fail) fail_q <= 1'b1;
            if (cap_hold) hold_q <= bus_rdata;
            if (cap_lo)   lo_q   <= bus_rdata;
            if (cap_hi)   result_q <= {bus_rdata, lo_q};
            if (finish) begin
                err_q <= fail_q | bus_err;
                if (fail_q | bus_err) result_q <= '0;
            end
        end
    end

    assign busy   = (state != S_IDLE);
    assign done   = done_q;
    assign err    = err_q;
    assign result = result_q;

endmodule

// File: rtl/cnv_seq_chk.sv
module cnv_seq_chk
    import cnv_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [RES_W-1:0]  result,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_ack,
    input logic              bus_err
);

    // R2: an idle request is taken up on the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R11: unanswered access keeps its address and data
    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R8: done lasts one cycle and comes with busy low
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: the access just before returning to idle is the disable write
    p_last_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bus_req && bus_we && bus_addr == A_CTRL1 && bus_wdata == V_OFF));

    // R10: a failed request reports a zero result
    p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (result == '0));

    // R4: the start write carries enable and buffer bits already set
    p_start_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == A_CTRL1 && (bus_wdata & M_START) != '0) |->
            ((bus_wdata & M_ENABLE) != '0 && (bus_wdata & M_BUFFER) != '0));

endmodule

bind cnv_seq_top cnv_seq_chk chk_i (.*);

// File: tb/cnv_seq_top_tb_top.sv
module cnv_seq_top_tb_top;

    localparam int TB_SETTLE  = 20;   // 10 kHz * 2000 us / 1000
    localparam int TB_TIMEOUT = 60;   // 10 kHz * 6 ms
    localparam int TB_TEMP    = 6;
    localparam int TB_POLLS   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_chan = '0;
    logic       busy, done, err;
    logic [15:0] result;
    logic       bus_req, bus_we;
    logic [7:0] bus_addr, bus_wdata;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       bus_err = 1'b0;
    logic       conv_irq = 1'b0;

    always #2 clk = ~clk;

    cnv_seq_top #(
        .CHAN_W(5), .TEMP_CHAN(TB_TEMP), .PULL_EN(1'b1), .POLL_LIMIT(TB_POLLS),
        .CLK_KHZ(10), .SETTLE_US(2000), .TIMEOUT_MS(6)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .busy(busy), .done(done), .err(err), .result(result),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err), .conv_irq(conv_irq)
    );

    // register-file model configuration (set by tasks, loaded on arm)
    logic arm = 1'b0;
    int cfg_pre, cfg_busy, cfg_lat, cfg_eidx, cfg_irqd, cfg_lo, cfg_hi;
    bit cfg_irq_on;

    int   cyc = 0;
    logic [7:0] m_ctrl1 = '0, m_ctrl2 = '0;
    int   busy_left = 0, acc_idx = 0, lat_cnt = 0, irq_cnt = 0, n_log = 0;
    logic [7:0] log_addr [0:63];
    logic [7:0] log_data [0:63];
    bit   log_we [0:63];
    bit   log_er [0:63];
    int   log_cyc [0:63];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq_cnt != 0) begin
            irq_cnt  <= irq_cnt - 1;
            conv_irq <= (irq_cnt == 1);
        end else begin
            conv_irq <= 1'b0;
        end
        if (arm) begin
            m_ctrl1   <= cfg_pre[7:0];
            busy_left <= cfg_busy;
            n_log     <= 0;
            acc_idx   <= 0;
            lat_cnt   <= 0;
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            irq_cnt   <= 0;
        end else if (bus_ack || bus_err) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end else if (bus_req) begin
            if (lat_cnt == cfg_lat) begin
                lat_cnt <= 0;
                acc_idx <= acc_idx + 1;
                if (n_log < 64) begin
                    log_addr[n_log] <= bus_addr;
                    log_data[n_log] <= bus_wdata;
                    log_we[n_log]   <= bus_we;
                    log_er[n_log]   <= (acc_idx == cfg_eidx);
                    log_cyc[n_log]  <= cyc;
                    n_log <= n_log + 1;
                end
                if (acc_idx == cfg_eidx) begin
                    bus_err <= 1'b1;
                end else begin
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        if (bus_addr == 8'h00) begin
                            m_ctrl1 <= bus_wdata;
                            if (bus_wdata[2] && cfg_irq_on) irq_cnt <= cfg_irqd;
                        end else if (bus_addr == 8'h01) begin
                            m_ctrl2 <= bus_wdata;
                        end
                    end else begin
                        case (bus_addr)
                            8'h00: bus_rdata <= m_ctrl1;
                            8'h04: begin
                                bus_rdata <= {7'b0, busy_left != 0};
                                if (busy_left != 0) busy_left <= busy_left - 1;
                            end
                            8'h05: bus_rdata <= cfg_lo[7:0];
                            8'h06: bus_rdata <= cfg_hi[7:0];
                            default: bus_rdata <= 8'h00;
                        endcase
                    end
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    int checks = 0;
    int failures = 0;
    bit ended = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk(1'b0, "R8 done never pulsed", 0, 1);
    endtask

    task automatic setup(input int pre, input int bsy, input int l, input int eidx,
                         input int irqd, input bit irq_on, input int lo, input int hi);
        @(negedge clk);
        cfg_pre = pre; cfg_busy = bsy; cfg_lat = l; cfg_eidx = eidx;
        cfg_irqd = irqd; cfg_irq_on = irq_on; cfg_lo = lo; cfg_hi = hi;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic run_req(input int ch, input int pre, input int bsy, input int l,
                           input int eidx, input int irqd, input bit irq_on,
                           input int lo, input int hi);
        setup(pre, bsy, l, eidx, irqd, irq_on, lo, hi);
        req_valid = 1'b1;
        req_chan  = ch[4:0];
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    function automatic int count_acc(input logic [7:0] a, input bit we);
        int c = 0;
        for (int i = 0; i < n_log; i++)
            if (log_addr[i] == a && log_we[i] == we) c++;
        return c;
    endfunction

    task automatic check_ok(input int ch, input int pre, input int bsy, input int l,
                            input int lo, input int hi);
        int pu, w1[4], nw, ilo, ihi, ic2, exp_gap;
        pu = (ch == TB_TEMP) ? 8 : 0;
        chk(result == 16'((hi << 8) | lo), "R7 result", int'(result), (hi << 8) | lo);
        chk(err == 1'b0, "R8 err on success", int'(err), 0);
        chk(count_acc(8'h04, 1'b0) == bsy + 1, "R3 status reads", count_acc(8'h04, 1'b0), bsy + 1);
        ic2 = -1;
        for (int i = 0; i < n_log; i++) if (log_addr[i] == 8'h01 && log_we[i]) ic2 = i;
        chk(count_acc(8'h01, 1'b1) == 1 && ic2 >= 0 && log_data[ic2] == 8'((ch | 8'h60)),
            "R4 ctrl2 write", (ic2 >= 0) ? int'(log_data[ic2]) : -1, ch | 8'h60);
        nw = 0;
        for (int i = 0; i < n_log; i++)
            if (log_addr[i] == 8'h00 && log_we[i]) begin
                if (nw < 4) w1[nw] = i;
                nw++;
            end
        chk(nw == 4, "R4 ctrl1 write count", nw, 4);
        if (nw == 4) begin
            chk(log_data[w1[0]] == 8'(pre | 8'h01), "R4 enable rmw", int'(log_data[w1[0]]), pre | 8'h01);
            chk(log_data[w1[1]] == 8'(pre | 8'h21 | pu), "R5 buffer rmw", int'(log_data[w1[1]]), pre | 8'h21 | pu);
            chk(log_data[w1[2]] == 8'(pre | 8'h25 | pu), "R4 start rmw", int'(log_data[w1[2]]), pre | 8'h25 | pu);
            chk(log_data[w1[3]] == 8'h00 && w1[3] == n_log - 1, "R8 final disable", int'(log_data[w1[3]]), 0);
            chk(w1[0] < ic2 && ic2 < w1[1], "R4 ctrl2 between enable and buffer", ic2, w1[0] + 1);
            exp_gap = (pu != 0) ? TB_SETTLE + 3 + l : 2 + l;
            chk(log_cyc[w1[1] + 1] - log_cyc[w1[1]] == exp_gap, "R5 buffer-to-start gap",
                log_cyc[w1[1] + 1] - log_cyc[w1[1]], exp_gap);
        end
        ilo = -1; ihi = -1;
        for (int i = 0; i < n_log; i++) begin
            if (log_addr[i] == 8'h05 && !log_we[i]) ilo = i;
            if (log_addr[i] == 8'h06 && !log_we[i]) ihi = i;
        end
        chk(ilo >= 0 && ihi == ilo + 1, "R7 low then high", ihi, ilo + 1);
    endtask

    task automatic check_fail(input string tag);
        chk(err == 1'b1, {tag, " err"}, int'(err), 1);
        chk(result == 16'h0, "R10 result zero on error", int'(result), 0);
        chk(n_log > 0 && log_we[n_log - 1] && log_addr[n_log - 1] == 8'h00 && log_data[n_log - 1] == 8'h00,
            "R8 last access is disable", (n_log > 0) ? int'(log_data[n_log - 1]) : -1, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lo, hi, l, pre, g, ws, ch_a;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0 && err == 1'b0, "R1 done/err", {done, err}, 0);
        chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
        chk(result == 16'h0, "R1 result", int'(result), 0);

        // sweep over every channel with varied wait counts, polls and presets
        for (int ch = 0; ch < 32; ch++) begin
            lo  = (ch * 37 + 11) & 8'hFF;
            hi  = ((ch * 13 + 5) ^ 8'hA5) & 8'hFF;
            l   = ch % 3;
            pre = (ch & 3) << 6;
            run_req(ch, pre, ch % 4, l, -1, 2 + ch % 5, 1'b1, lo, hi);
            check_ok(ch, pre, ch % 4, l, lo, hi);
        end
        // pull-up channel with a longer bus wait
        run_req(TB_TEMP, 8'h02, 1, 3, -1, 4, 1'b1, 8'h3C, 8'h03);
        check_ok(TB_TEMP, 8'h02, 1, 3, 8'h3C, 8'h03);

        // R3 poll limit boundary: 9 busy reads succeed, 10 fail
        run_req(4, 0, TB_POLLS - 1, 0, -1, 3, 1'b1, 8'h55, 8'h01);
        check_ok(4, 0, TB_POLLS - 1, 0, 8'h55, 8'h01);
        run_req(4, 0, TB_POLLS, 1, -1, 3, 1'b1, 8'h55, 8'h01);
        check_fail("R3 poll exhausted");
        chk(count_acc(8'h04, 1'b0) == TB_POLLS, "R3 status reads on fail", count_acc(8'h04, 1'b0), TB_POLLS);
        chk(count_acc(8'h01, 1'b1) == 0, "R3 no ctrl2 write", count_acc(8'h01, 1'b1), 0);

        // R6 timeout windows
        for (int k = 0; k < 3; k++) begin
            run_req(9, 0, 0, k, -1, 0, 1'b0, 8'h11, 8'h22);
            check_fail("R6 timeout");
            ws = -1;
            for (int i = 0; i < n_log; i++)
                if (log_we[i] && log_addr[i] == 8'h00 && log_data[i][2]) ws = i;
            g = (ws >= 0 && ws + 1 < n_log) ? log_cyc[ws + 1] - log_cyc[ws] : -1;
            chk(g == TB_TIMEOUT + 3 + k, "R6 timeout gap", g, TB_TIMEOUT + 3 + k);
        end
        // R6 late interrupt still inside the window
        run_req(9, 0, 0, 1, -1, TB_TIMEOUT, 1'b1, 8'h77, 8'h02);
        check_ok(9, 0, 0, 1, 8'h77, 8'h02);

        // R9 bus error on each access position, including the disable write
        for (int e = 0; e <= 10; e++) begin
            run_req(3, 0, 0, e % 2, e, 3, 1'b1, 8'h99, 8'h03);
            check_fail("R9 bus error");
            chk(n_log == ((e == 10) ? 11 : e + 2), "R9 no access after error but disable", n_log,
                (e == 10) ? 11 : e + 2);
            chk(log_er[e], "R9 error position", int'(log_er[e]), 1);
        end

        // R2 request while busy is ignored
        ch_a = 12;
        setup(0, 1, 2, -1, 30, 1'b1, 8'h40, 8'h02);
        req_valid = 1'b1;
        req_chan  = 5'(ch_a);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        req_chan = 5'd17;
        repeat (12) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        check_ok(ch_a, 0, 1, 2, 8'h40, 8'h02);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2 no second conversion", int'(busy), 0);

        ended = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule